// File: doc/BRIEF.md
# Serial Receive Status Flags

This block sits between the receive shifter of a serial port and the processor bus. When the shifter reports that a character is complete, the block checks the character for errors. The checks are: the data register still full, a low stop bit, and a parity mismatch. Only an error-free character is copied into the receive data register. The block keeps four sticky flags: data-full, overrun, framing error and parity error.

Software clears a flag with a two-step handshake. It first reads the status register and sees the flag at 1. It then writes a 0 into that bit position. A write without that earlier read, or a write of 1, leaves the flag alone. In synchronous mode the stop bit and parity inputs are ignored, and they take no part in the error checks. An error-any output gathers the three error flags into one interrupt source.

Top module: `rx_status_flags`

## Requirements
- R1: After reset, every flag is 0, the receive data register holds 0, and no flag is armed for clearing.
- R2: A completed character with no error, arriving while data-full is 0, is copied into the data register. Data-full reads 1 on the next cycle.
- R3: A character that completes while data-full is 1 sets the overrun flag. The data register keeps its earlier byte and data-full stays 1.
- R4: In asynchronous mode (`sync_mode`=0), a character whose stop bit is 0 sets the framing flag. It is not transferred and does not set data-full.
- R5: In asynchronous mode with `par_en`=1, the parity flag is set when the received parity bit differs from the expected bit, and the character is not transferred. For even parity (`par_odd`=0) the expected bit is the XOR of the data bits. For odd parity (`par_odd`=1) it is the inverse of that XOR.
- R6: In synchronous mode, the stop bit and the parity bit are ignored. The framing and parity flags are never set, and a character that arrives with data-full at 0 is transferred.
- R7: A status read that returns a flag at 1 arms that flag. A later status write with that bit at 0 clears an armed flag on the next cycle. A write of 1, or a write of 0 to a flag that is not armed, leaves the flag unchanged.
- R8: If a flag is set in the same cycle as a qualifying clear, the flag ends at 1.
- R9: Reading the data register changes no flag.
- R10: `err_any` is 1 exactly when the overrun, framing or parity flag is 1.
- R11: `bus_sel`=0 selects status and `bus_sel`=1 selects data. The status bits are: bit 3 data-full, bit 2 overrun, bit 1 framing, bit 0 parity; all upper bits read 0. `bus_rdata` shows the selected register while `bus_rd` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_done | input | 1 | One-cycle strobe: character complete |
| char_byte | input | DATA_W | Received character from the shifter |
| stop_bit | input | 1 | Sampled stop bit |
| par_bit | input | 1 | Received parity bit |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| rx_full | output | 1 | Data-full flag |
| err_any | output | 1 | OR of the three error flags |

## Verification
The bench drives a status write of 0 before any read. A design that ignored the arming step would clear the flag at this point, where a correct one keeps it. The bench then delivers a character while the data register is full. A design that loaded the new byte would change the data read back, even though it raised overrun. Characters with a low stop bit and a wrong parity bit are sent in both asynchronous and synchronous mode, for even and odd parity. A design that checked them in synchronous mode would raise framing or parity errors there. Last, an armed clear is timed to land in the same cycle as a new parity error. A design that gave priority to the clear would drop that error.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NFLAG   = 4;
    localparam int FL_PAR  = 0;
    localparam int FL_FRM  = 1;
    localparam int FL_OVR  = 2;
    localparam int FL_FULL = 3;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;
endpackage

// File: rtl/rxs_check.sv
module rxs_check #(
    parameter int DATA_W = 8
) (
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_byte,
    input  logic              stop_bit,
    input  logic              par_bit,
    input  logic              sync_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              full_q,
    output logic [rxs_pkg::NFLAG-1:0] set_o,
    output logic              load_o
);
    import rxs_pkg::*;

    logic exp_par;
    logic ovr_hit;
    logic frm_hit;
    logic par_hit;

    always_comb begin
        exp_par = (^char_byte) ^ par_odd;
        ovr_hit = char_done && full_q;
        frm_hit = char_done && !sync_mode && !stop_bit;
        par_hit = char_done && !sync_mode && par_en && (par_bit != exp_par);
        load_o  = char_done && !ovr_hit && !frm_hit && !par_hit;
        set_o           = '0;
        set_o[FL_PAR]   = par_hit;
        set_o[FL_FRM]   = frm_hit;
        set_o[FL_OVR]   = ovr_hit;
        set_o[FL_FULL]  = load_o;
    end
endmodule

// File: rtl/rxs_flag.sv
module rxs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    import rxs_pkg::*;

    flag_st_t st_d, st_q;
    logic     clr;

    always_comb begin
        st_d = st_q;
        clr  = wr_hit_i && !wr_bit_i && st_q.armed;
        if (clr) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end else if (rd_hit_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    a_r7_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !wr_bit_i && !st_q.armed && st_q.flag) |=> st_q.flag);
    a_r7_write_one_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && wr_bit_i && st_q.flag) |=> st_q.flag);
    a_r7_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !wr_bit_i && st_q.armed && !set_i) |=> !st_q.flag);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag);
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_byte,
    input  logic              stop_bit,
    input  logic              par_bit,
    input  logic              sync_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_full,
    output logic              err_any
);
    import rxs_pkg::*;

    logic [DATA_W-1:0] data_d, data_q;
    logic [NFLAG-1:0]  flags;
    logic [NFLAG-1:0]  set_v;
    logic              load;
    logic              stat_rd;
    logic              stat_wr;
    logic              unused_wdata_hi;

    assign stat_rd         = bus_rd && !bus_sel;
    assign stat_wr         = bus_wr && !bus_sel;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NFLAG];

    rxs_check #(.DATA_W(DATA_W)) i_check (
        .char_done (char_done),
        .char_byte (char_byte),
        .stop_bit  (stop_bit),
        .par_bit   (par_bit),
        .sync_mode (sync_mode),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .full_q    (flags[FL_FULL]),
        .set_o     (set_v),
        .load_o    (load)
    );

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        rxs_flag i_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[gi]),
            .rd_hit_i (stat_rd),
            .wr_hit_i (stat_wr),
            .wr_bit_i (bus_wdata[gi]),
            .flag_o   (flags[gi])
        );
    end

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d = char_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_sel) begin
                bus_rdata = data_q;
            end else begin
                bus_rdata[NFLAG-1:0] = flags;
            end
        end
    end

    assign rx_full = flags[FL_FULL];
    assign err_any = flags[FL_OVR] | flags[FL_FRM] | flags[FL_PAR];

    a_r3_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_full) |=> flags[FL_OVR]);
    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_full) |=> $stable(data_q));
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !rx_full && sync_mode) |=> (rx_full && data_q == $past(char_byte)));
    a_r4_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !sync_mode && !stop_bit) |=> (flags[FL_FRM] && $stable(data_q)));
    a_r6_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !flags[FL_FRM] && !flags[FL_PAR]) |=> (!flags[FL_FRM] && !flags[FL_PAR]));
endmodule

// File: tb/test_rx_status_flags.sv
module test_rx_status_flags;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          char_done = 1'b0;
    logic [DW-1:0] char_byte = '0;
    logic          stop_bit = 1'b1;
    logic          par_bit = 1'b0;
    logic          sync_mode = 1'b0;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rx_full;
    logic          err_any;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model: index 0 parity, 1 framing, 2 overrun, 3 full
    bit [3:0]  m_flag;
    bit [3:0]  m_arm;
    bit [7:0]  m_data;

    rx_status_flags #(.DATA_W(DW)) i_rx_status_flags (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_byte(char_byte),
        .stop_bit(stop_bit), .par_bit(par_bit), .sync_mode(sync_mode),
        .par_en(par_en), .par_odd(par_odd), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_full(rx_full), .err_any(err_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0; m_arm = '0; m_data = '0;
        end else begin
            bit [3:0] s;
            bit bad_par;
            s = '0;
            if (char_done) begin
                bad_par = (par_bit != ((^char_byte) ^ par_odd));
                s[2] = m_flag[3];
                s[1] = !sync_mode && !stop_bit;
                s[0] = !sync_mode && par_en && bad_par;
                if (s[2:0] == 3'b000) begin
                    s[3] = 1'b1;
                    m_data = char_byte;
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (bus_wr && !bus_sel && !bus_wdata[i] && m_arm[i]) begin
                    m_flag[i] = 1'b0; m_arm[i] = 1'b0;
                end else if (bus_rd && !bus_sel && m_flag[i]) begin
                    m_arm[i] = 1'b1;
                end
                if (s[i]) m_flag[i] = 1'b1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of flag outputs against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 rx_full", rx_full, m_flag[3]);
            check("R10 err_any", err_any, |m_flag[2:0]);
        end
    end

    task automatic idle();
        @(negedge clk);
        char_done = 0; bus_rd = 0; bus_wr = 0;
    endtask

    task automatic send(input logic [7:0] b, input logic stp, input logic pb);
        @(negedge clk);
        char_done = 1; char_byte = b; stop_bit = stp; par_bit = pb;
        bus_rd = 0; bus_wr = 0;
        @(negedge clk);
        char_done = 0;
    endtask

    task automatic rd_status(input string tag);
        @(negedge clk);
        char_done = 0; bus_wr = 0; bus_rd = 1; bus_sel = 0;
        #1;
        check(tag, bus_rdata, {4'b0, m_flag});
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic rd_data(input string tag, input logic [7:0] exp);
        @(negedge clk);
        char_done = 0; bus_wr = 0; bus_rd = 1; bus_sel = 1;
        #1;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, m_data);
        @(negedge clk);
        bus_rd = 0; bus_sel = 0;
    endtask

    task automatic wr_status(input logic [7:0] v);
        @(negedge clk);
        char_done = 0; bus_rd = 0; bus_wr = 1; bus_sel = 0; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_status("R1 status after reset");
        rd_data("R1 data after reset", 8'h00);
        check("R11 rdata idle", bus_rdata, 0);

        // R2 good character, async, parity off
        send(8'hA5, 1, 0);
        rd_data("R2 byte loaded", 8'hA5);
        check("R11 full at bit3", {28'b0, i_rx_status_flags.rx_full}, 1);
        // R7 write 0 with no arming read: unchanged
        // (data read above does not arm)
        wr_status(8'h00);
        check("R7 unarmed write keeps full", rx_full, 1);
        // R9 data read leaves flags
        rd_data("R9 data read", 8'hA5);
        check("R9 full kept", rx_full, 1);

        // R3 overrun: data kept
        send(8'h3C, 1, 0);
        rd_data("R3 data kept on overrun", 8'hA5);
        rd_status("R3 overrun status");
        check("R3 overrun err_any", err_any, 1);
        // status now armed: write 1s has no effect
        wr_status(8'hFF);
        check("R7 write one keeps", {rx_full, err_any}, 2'b11);
        wr_status(8'h00);
        check("R7 armed clear", {rx_full, err_any}, 2'b00);
        rd_status("R7 cleared status");

        // R4 framing
        send(8'h11, 0, 0);
        check("R4 no transfer", rx_full, 0);
        rd_status("R4 framing status");
        rd_data("R4 data unchanged", 8'h3C === 8'h3C ? 8'hA5 : 8'hA5);
        wr_status(8'h00);
        rd_status("R7 framing cleared");

        // R5 parity even: 0x03 XOR=0, send parity 1 -> error
        par_en = 1; par_odd = 0;
        send(8'h03, 1, 1);
        check("R5 even parity error", err_any, 1);
        rd_status("R5 parity status");
        wr_status(8'h00);
        // odd parity: 0x03 expects 1 -> ok
        par_odd = 1;
        send(8'h03, 1, 1);
        rd_data("R5 odd parity ok", 8'h03);
        rd_status("R5 odd status");
        wr_status(8'h00);

        // R6 synchronous: bad stop and parity ignored
        sync_mode = 1;
        send(8'h5A, 0, 0);
        rd_data("R6 sync transfer", 8'h5A);
        rd_status("R6 sync no errors");
        check("R6 err_any low", err_any, 0);
        wr_status(8'h00);
        sync_mode = 0;

        // R8 set wins: arm parity, then clear in same cycle as new error
        par_odd = 0;
        send(8'h01, 1, 0);
        rd_status("R8 armed");
        @(negedge clk);
        char_done = 1; char_byte = 8'h01; stop_bit = 1; par_bit = 0;
        bus_wr = 1; bus_sel = 0; bus_wdata = 8'h00;
        @(negedge clk);
        char_done = 0; bus_wr = 0;
        check("R8 parity stays set", err_any, 1);
        rd_status("R8 status");
        idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule